// File: doc/BRIEF.md
# Streaming Horizontal Gradient Filter

This block computes a horizontal centred-difference gradient over a raster image that arrives as a pixel stream. Pixels are unsigned and come in row-major order, one per beat marked by an input valid strobe. A last flag on the final pixel of each row is the only row delimiter. For each pixel the block emits one signed sample: the right neighbour minus the left neighbour. At the start and end of a row, the missing neighbour is replaced by the nearest pixel in that row.

The result for a column cannot be formed until the next pixel arrives. A row's last pixel therefore releases two samples at once. A single output slot plus one holding entry absorbs the second sample. It drains on the next beat, which is always the first pixel of a new row and produces no sample of its own, or on any idle cycle. There is no backpressure. The block accepts any row length and any number of rows, including one-pixel rows.

Top module: `rowgrad_top`

## Requirements
- R1: For an interior column x of a row, the output sample equals pixel(x+1) minus pixel(x-1) of the same row. It is a two's-complement value one bit wider than the pixel.
- R2: At the row edges the missing neighbour is replaced by the edge pixel. Column 0 yields pixel(1) minus pixel(0), and column W-1 yields pixel(W-1) minus pixel(W-2). The first pixel of a row never produces a sample in the cycle after it is accepted, unless it is also the row's last pixel.
- R3: A row with a single pixel (input last set on its first pixel) yields exactly one sample, with value 0 and the output last flag set.
- R4: The output last flag is 1 on the sample for the final column of each row and 0 on every other sample. When a row of two or more pixels ends, its second-to-last and last samples appear on two consecutive cycles, in that order.
- R5: Every accepted input pixel yields exactly one output sample. Samples leave in the same row-major order as the input, with none dropped or duplicated.
- R6: Input valid may stay high across row boundaries. The first pixel of a row may follow the previous row's last pixel on the very next cycle with no loss of samples.
- R7: Cycles with input valid low do not advance the filter state. When no sample is held, the output valid is low in the following cycle.
- R8: While the active-low reset is asserted, output valid is low. After reset, a partially received row is forgotten and the next pixel starts a new row.
- R9: Full-scale inputs do not wrap. A row of 0, max, 0 produces +max, 0 and -max, where max is 2^PIX_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Input pixel valid strobe |
| in_last_i | input | 1 | Marks the final pixel of a row |
| in_pix_i | input | PIX_W | Unsigned pixel value |
| out_valid_o | output | 1 | Output sample valid |
| out_last_o | output | 1 | Marks the sample of a row's final column |
| out_grad_o | output | PIX_W+1 | Signed gradient sample |

## Verification
The assertions assume the source honours the framing. The last flag is meaningful only with valid. Nothing is sent during the two cycles in which the internal reset is still held after the external release. Under those conditions the holding entry can never be asked to hold a second row-end sample. The bench waits out the reset synchroniser before driving. It builds every row with exactly one last flag, on its final pixel. Random idle gaps are inserted only between beats, never inside a beat.

// File: rtl/rowgrad_pkg.sv
package rowgrad_pkg;

  // Position of the filter within the current row
  typedef enum logic [1:0] {
    ROW_EMPTY = 2'd0,  // no pixel of the current row held
    ROW_ONE   = 2'd1,  // only the row's first pixel held
    ROW_MANY  = 2'd2   // at least two pixels of the row seen
  } row_state_e;

endpackage

// File: rtl/rowgrad_rst_sync.sv
module rowgrad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/rowgrad_core.sv
module rowgrad_core
  import rowgrad_pkg::*;
#(
  parameter int PIX_W = 14,
  localparam int OUT_W = PIX_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic                    in_last_i,
  input  logic [PIX_W-1:0]        in_pix_i,
  output logic                    emit0_v_o,
  output logic signed [OUT_W-1:0] emit0_d_o,
  output logic                    emit0_l_o,
  output logic                    emit1_v_o,
  output logic signed [OUT_W-1:0] emit1_d_o,
  output row_state_e              row_st_o
);

  row_state_e       state_q, state_d;
  logic [PIX_W-1:0] left_q, left_d;
  logic [PIX_W-1:0] cur_q, cur_d;
  logic             adv;

  function automatic logic signed [OUT_W-1:0] diff(input logic [PIX_W-1:0] a,
                                                   input logic [PIX_W-1:0] b);
    return $signed({1'b0, a}) - $signed({1'b0, b});
  endfunction

  assign adv = in_valid_i;

  // Sample producers
  always_comb begin
    emit0_v_o = in_valid_i && ((state_q != ROW_EMPTY) || in_last_i);
    emit0_l_o = in_last_i && (state_q == ROW_EMPTY);
    if (state_q == ROW_EMPTY) begin
      emit0_d_o = '0;
    end else if (state_q == ROW_MANY) begin
      emit0_d_o = diff(in_pix_i, left_q);
    end else begin
      emit0_d_o = diff(in_pix_i, cur_q);
    end
    emit1_v_o = in_valid_i && in_last_i && (state_q != ROW_EMPTY);
    emit1_d_o = diff(in_pix_i, cur_q);
  end

  // Next state
  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    cur_d   = cur_q;
    if (adv) begin
      left_d = cur_q;
      cur_d  = in_pix_i;
      if (in_last_i) begin
        state_d = ROW_EMPTY;
      end else if (state_q == ROW_EMPTY) begin
        state_d = ROW_ONE;
      end else begin
        state_d = ROW_MANY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ROW_EMPTY;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      cur_q  <= '0;
    end else if (adv) begin
      left_q <= left_d;
      cur_q  <= cur_d;
    end
  end

  assign row_st_o = state_q;

endmodule

// File: rtl/rowgrad_outbuf.sv
module rowgrad_outbuf #(
  parameter int OUT_W = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    e0_v_i,
  input  logic signed [OUT_W-1:0] e0_d_i,
  input  logic                    e0_l_i,
  input  logic                    e1_v_i,
  input  logic signed [OUT_W-1:0] e1_d_i,
  output logic                    hold_v_o,
  output logic                    out_v_o,
  output logic                    out_l_o,
  output logic signed [OUT_W-1:0] out_d_o
);

  logic                    out_v_q, out_v_d;
  logic                    out_l_q, out_l_d;
  logic signed [OUT_W-1:0] out_d_q, out_d_d;
  logic                    hold_v_q, hold_v_d;
  logic                    hold_l_q, hold_l_d;
  logic signed [OUT_W-1:0] hold_d_q, hold_d_d;
  logic                    out_en, hold_en;

  always_comb begin
    out_v_d  = 1'b0;
    out_l_d  = out_l_q;
    out_d_d  = out_d_q;
    hold_v_d = 1'b0;
    hold_l_d = hold_l_q;
    hold_d_d = hold_d_q;
    out_en   = 1'b0;
    hold_en  = 1'b0;
    if (hold_v_q) begin
      // oldest sample first; the new one (never two) waits in the hold entry
      out_v_d  = 1'b1;
      out_l_d  = hold_l_q;
      out_d_d  = hold_d_q;
      out_en   = 1'b1;
      hold_v_d = e0_v_i;
      hold_l_d = e0_l_i;
      hold_d_d = e0_d_i;
      hold_en  = e0_v_i;
    end else if (e0_v_i) begin
      out_v_d  = 1'b1;
      out_l_d  = e0_l_i;
      out_d_d  = e0_d_i;
      out_en   = 1'b1;
      hold_v_d = e1_v_i;
      hold_l_d = 1'b1;
      hold_d_d = e1_d_i;
      hold_en  = e1_v_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q  <= 1'b0;
      hold_v_q <= 1'b0;
    end else begin
      out_v_q  <= out_v_d;
      hold_v_q <= hold_v_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_l_q <= 1'b0;
      out_d_q <= '0;
    end else if (out_en) begin
      out_l_q <= out_l_d;
      out_d_q <= out_d_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= 1'b0;
      hold_d_q <= '0;
    end else if (hold_en) begin
      hold_l_q <= hold_l_d;
      hold_d_q <= hold_d_d;
    end
  end

  assign hold_v_o = hold_v_q;
  assign out_v_o  = out_v_q;
  assign out_l_o  = out_l_q && out_v_q;
  assign out_d_o  = out_d_q;

endmodule

// File: rtl/rowgrad_top.sv
module rowgrad_top
  import rowgrad_pkg::*;
#(
  parameter int PIX_W = 14,
  localparam int OUT_W = PIX_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic                    in_last_i,
  input  logic [PIX_W-1:0]        in_pix_i,
  output logic                    out_valid_o,
  output logic                    out_last_o,
  output logic signed [OUT_W-1:0] out_grad_o
);

  logic                    rst_sync_n;
  logic                    e0_v, e0_l, e1_v, hold_v;
  logic signed [OUT_W-1:0] e0_d, e1_d;
  row_state_e              row_st;

  rowgrad_rst_sync #(.STAGES(2)) rst_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  rowgrad_core #(.PIX_W(PIX_W)) core_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .in_pix_i   (in_pix_i),
    .emit0_v_o  (e0_v),
    .emit0_d_o  (e0_d),
    .emit0_l_o  (e0_l),
    .emit1_v_o  (e1_v),
    .emit1_d_o  (e1_d),
    .row_st_o   (row_st)
  );

  rowgrad_outbuf #(.OUT_W(OUT_W)) obuf_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .e0_v_i   (e0_v),
    .e0_d_i   (e0_d),
    .e0_l_i   (e0_l),
    .e1_v_i   (e1_v),
    .e1_d_i   (e1_d),
    .hold_v_o (hold_v),
    .out_v_o  (out_valid_o),
    .out_l_o  (out_last_o),
    .out_d_o  (out_grad_o)
  );

endmodule

// File: rtl/rowgrad_chk.sv
module rowgrad_chk
  import rowgrad_pkg::*;
#(
  parameter int PIX_W = 14,
  localparam int OUT_W = PIX_W + 1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    in_last_i,
  input row_state_e              row_st,
  input logic                    hold_v,
  input logic                    e1_v,
  input logic                    out_valid_o,
  input logic                    out_last_o,
  input logic signed [OUT_W-1:0] out_grad_o
);

  assert_last_qual_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  assert_row_end_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_last_i && row_st != ROW_EMPTY)
      |=> (out_valid_o && !out_last_o) ##1 (out_valid_o && out_last_o));

  assert_single_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_last_i && row_st == ROW_EMPTY && !hold_v)
      |=> (out_valid_o && out_last_o && out_grad_o == '0));

  assert_first_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_last_i && row_st == ROW_EMPTY && !hold_v) |=> !out_valid_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !hold_v) |=> !out_valid_o);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_v |-> !e1_v);

endmodule

bind rowgrad_top rowgrad_chk #(.PIX_W(PIX_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .in_valid_i  (in_valid_i),
  .in_last_i   (in_last_i),
  .row_st      (row_st),
  .hold_v      (hold_v),
  .e1_v        (e1_v),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .out_grad_o  (out_grad_o)
);

// File: tb/rowgrad_top_tb_top.sv
module rowgrad_top_tb_top;

  localparam int PW   = 14;
  localparam int OW   = PW + 1;
  localparam int PMAX = (1 << PW) - 1;

  typedef struct {
    int    v;
    bit    last;
    string tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          in_valid_i;
  logic          in_last_i;
  logic [PW-1:0] in_pix_i;
  logic          out_valid_o;
  logic          out_last_o;
  logic [OW-1:0] out_grad_o;

  int   checks   = 0;
  int   failures = 0;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  rowgrad_top #(.PIX_W(PW)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .in_pix_i    (in_pix_i),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .out_grad_o  (out_grad_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Output monitor: every sample is matched in order against the model queue
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && out_valid_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected sample", int'($signed(out_grad_o)), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'($signed(out_grad_o)) == e.v, {e.tag, " value"},
              int'($signed(out_grad_o)), e.v);
        check(out_last_o == e.last, "R4 last flag", int'(out_last_o), int'(e.last));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  function automatic int grad_at(const ref int pix[], input int w, input int y, input int x);
    int r, l;
    r = (x + 1 > w - 1) ? w - 1 : x + 1;
    l = (x - 1 < 0) ? 0 : x - 1;
    return pix[y * w + r] - pix[y * w + l];
  endfunction

  // mode 0: random, mode 1: alternating 0 / full scale
  task automatic run_image(input int w, input int h, input int gap_pct,
                           input int mode, input string tag);
    int pix[];
    int waitc;
    pix = new[w * h];
    foreach (pix[i]) pix[i] = (mode == 1) ? ((i % 2 == 1) ? PMAX : 0)
                                          : int'($urandom_range(PMAX, 0));
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        exp_t e;
        e.v    = grad_at(pix, w, y, x);
        e.last = (x == w - 1);
        e.tag  = tag;
        exp_q.push_back(e);
      end
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        if (gap_pct > 0 && int'($urandom_range(99, 0)) < gap_pct) begin
          int n;
          n = int'($urandom_range(3, 1));
          @(negedge clk_i);
          in_valid_i = 1'b0;
          in_last_i  = 1'b0;
          repeat (n - 1) @(negedge clk_i);
        end
        @(negedge clk_i);
        in_valid_i = 1'b1;
        in_last_i  = (x == w - 1);
        in_pix_i   = PW'(pix[y * w + x]);
      end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
    waitc = 0;
    while (exp_q.size() != 0 && waitc < 8) begin
      @(negedge clk_i);
      waitc++;
    end
    check(exp_q.size() == 0, "R5 all samples delivered", exp_q.size(), 0);
    exp_q.delete();
    // R7: with nothing pending, output valid stays low
    repeat (3) begin
      @(negedge clk_i);
      check(out_valid_o == 1'b0, "R7 idle output", int'(out_valid_o), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_ni     = 1'b0;
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
    in_pix_i   = '0;
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 1'b0, "R8 reset output valid", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    run_image(1, 1, 0, 0, "R3 one by one");
    run_image(1, 6, 0, 0, "R3 R6 single column");
    run_image(2, 3, 0, 0, "R2 two wide");
    run_image(3, 2, 0, 1, "R9 full scale");
    run_image(4, 3, 0, 1, "R9 alternating");
    run_image(16, 1, 40, 0, "R7 gaps");
    run_image(9, 4, 0, 0, "R1 R6 back to back");

    // R8: reset in the middle of a row, then a fresh image
    begin
      exp_t e;
      @(negedge clk_i); in_valid_i = 1'b1; in_last_i = 1'b0; in_pix_i = PW'(100);
      @(negedge clk_i); in_pix_i = PW'(250);
      @(negedge clk_i); in_pix_i = PW'(40);
      e.last = 1'b0; e.tag = "R8 before reset";
      e.v = 150; exp_q.push_back(e);
      e.v = -60; exp_q.push_back(e);
      @(negedge clk_i); in_valid_i = 1'b0;
      @(negedge clk_i);
      @(negedge clk_i);
      check(exp_q.size() == 0, "R8 pre-reset samples", exp_q.size(), 0);
      rst_ni = 1'b0;
      @(negedge clk_i);
      check(out_valid_o == 1'b0, "R8 valid low in reset", int'(out_valid_o), 0);
      @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (4) @(negedge clk_i);
      run_image(5, 2, 0, 0, "R8 after reset");
    end

    for (int k = 0; k < 25; k++) begin
      run_image(int'($urandom_range(12, 1)), int'($urandom_range(5, 1)),
                (k % 2 == 0) ? 0 : 30, 0, "R1 R2 R5 random");
    end

    finish_run();
  end

endmodule